// File: doc/BRIEF.md
# Display Controller Command Queue and Decoder

This block is the host-facing front end of a display timing controller. The host writes bytes on two strobes that share one data bus: one strobe marks a command byte and the other a parameter byte. Every write enters a queue as a 9-bit entry whose top bit flags a command. The decoder pops one entry for each cycle in which the processing-step input is high. It decodes the entries strictly in the order they were written.

A command entry selects what the following parameter bytes mean and resets the parameter step count. Several opcodes carry an operand in their low bits: a display-enable bit, a master-sync bit, or a starting index into a 16-byte parameter RAM. Parameter entries then fill the raster timing fields, the line pitch or the cursor address, or they stream into the parameter RAM through a write port.

A status byte reports the queue level, the video blanking state and whether read data is ready. A sticky flag records any write that was lost because the queue was full.

Top module: `gdc_cmd_front`

## Requirements
- R1: An entry is one data byte plus a command flag (set for `wr_cmd`, clear for `wr_param`). At most one entry is decoded per cycle with `step_en` high, in write order. Nothing is decoded while `step_en` is low.
- R2: `status` is formed as follows. Bit 2 is set when the queue is empty. Bit 1 is set when the queue is full. Bit 0 follows `rd_ready`. Bit 5 follows `vretrace`. Bit 6 is `hblank` OR `vblank`. Bits 7, 4 and 3 read 0.
- R3: A write while the queue holds DEPTH entries is dropped and sets `overrun`, which stays set until reset.
- R4: Opcode 0x00 does the following. It clears `disp_en` and sets `idle`. It discards every entry still queued, so status bit 2 reads 1 in the cycle that follows. It pulses `rb_clr` for one cycle. Its next 8 parameter bytes load the timing fields as in R6.
- R5: Opcodes 0x0C/0x0D and 0x0E/0x0F set `disp_en` to opcode bit 0. Opcode 0x6B sets `disp_en` and clears `idle`.
- R6: After opcode 0x0E/0x0F (or 0x00), the timing fields update together when the eighth parameter byte (B0 to B7) arrives, decoded as follows:
  - from B0: `disp_mode` = {B0[5],B0[1]}, `framing` = {B0[3],B0[0]}, `draw_retrace` = B0[4], `refresh_en` = B0[2];
  - `words_per_line` = B1+2;
  - from B2: `hsync_w` = B2[4:0]+1;
  - `vsync_w` = {B3[1:0],B2[7:5]};
  - from B3: `hfp_w` = B3[7:2]+1;
  - from B4: `hbp_w` = B4[5:0]+1;
  - from B5: `vfp_w` = B5[5:0];
  - `active_lines` = {B7[1:0],B6};
  - from B7: `vbp_w` = B7[7:2].
- R7: Opcodes 0x6E/0x6F set `master_sync` to opcode bit 0.
- R8: Opcodes 0x70 to 0x7F set the RAM pointer to the opcode's low nibble. Each later parameter byte gives one `pram_we` pulse carrying the pointer and the byte, and the pointer then advances modulo 16.
- R9: Opcode 0x49 takes three bytes into `cursor_addr`: [7:0], then [15:8], then [17:16] from bits [1:0] of the third byte.
- R10: Opcode 0x47 takes one byte into `pitch`; a zero byte gives 256.
- R11: Parameter bytes beyond a command's count, and parameter bytes after an opcode that takes none, change no output.
- R12: After reset, the outputs take these values:
  - `disp_en`=1 and `idle`=0;
  - `master_sync`=0 and `overrun`=0;
  - `pitch`=256;
  - the cursor address and all timing fields are 0;
  - `status`=0x04 when the status inputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cmd | input | 1 | Write `wr_data` as a command entry (wins if both strobes are high) |
| wr_param | input | 1 | Write `wr_data` as a parameter entry |
| wr_data | input | 8 | Host write byte |
| step_en | input | 1 | Processing step: permits one entry to be decoded |
| rd_ready | input | 1 | Read-back data available (status bit 0) |
| hblank | input | 1 | Horizontal blanking |
| vblank | input | 1 | Vertical blanking |
| vretrace | input | 1 | Vertical retrace |
| status | output | 8 | Status byte |
| overrun | output | 1 | Sticky lost-write flag |
| disp_en | output | 1 | Display enable |
| idle | output | 1 | Controller idle |
| master_sync | output | 1 | Generate own vertical sync |
| disp_mode | output | 2 | Display mode |
| framing | output | 2 | Video framing |
| draw_retrace | output | 1 | Draw only in retrace |
| refresh_en | output | 1 | Memory refresh enable |
| words_per_line | output | 9 | Active words per line |
| hsync_w | output | 6 | Horizontal sync width |
| vsync_w | output | 5 | Vertical sync width |
| hfp_w | output | 7 | Horizontal front porch |
| hbp_w | output | 7 | Horizontal back porch |
| vfp_w | output | 6 | Vertical front porch |
| active_lines | output | 10 | Active lines per field |
| vbp_w | output | 6 | Vertical back porch |
| pitch | output | 9 | Line pitch in words |
| cursor_addr | output | 18 | Cursor address |
| pram_we | output | 1 | Parameter RAM write strobe |
| pram_addr | output | 4 | Parameter RAM write address |
| pram_wdata | output | 8 | Parameter RAM write data |
| rb_clr | output | 1 | One-cycle clear request to the read-back queue |

## Verification
A stale current-command or step count is the likeliest internal fault. It shows at the ports as parameter bytes landing in the wrong field, or as bytes that should be ignored changing an output, two cycles after the byte is written with `step_en` high. Queue pointer or count faults show on the status byte at once, and as missing, extra or reordered RAM write pulses as the queue drains. The bench therefore compares every RAM write pulse against an expected ordered list, so drops and reorderings are caught where they occur rather than only at the end.

// File: rtl/gdc_cmd_pkg.sv
package gdc_cmd_pkg;

  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned ENTRY_W = BYTE_W + 1;
  localparam int unsigned PRAM_AW = 4;

  localparam logic [7:0] OP_RESET  = 8'h00;
  localparam logic [7:0] OP_BLANK  = 8'h0C;
  localparam logic [7:0] OP_SYNC   = 8'h0E;
  localparam logic [7:0] OP_PITCH  = 8'h47;
  localparam logic [7:0] OP_CURSOR = 8'h49;
  localparam logic [7:0] OP_START  = 8'h6B;
  localparam logic [7:0] OP_VSMODE = 8'h6E;
  localparam logic [7:0] OP_PRAM   = 8'h70;

  typedef enum logic [2:0] {
    PM_NONE,
    PM_TIMING,
    PM_PITCH,
    PM_CURSOR,
    PM_PRAM
  } param_mode_e;

  typedef struct packed {
    logic [1:0] disp_mode;
    logic [1:0] framing;
    logic       draw_retrace;
    logic       refresh_en;
    logic [8:0] words;
    logic [5:0] hsync;
    logic [4:0] vsync;
    logic [6:0] hfp;
    logic [6:0] hbp;
    logic [5:0] vfp;
    logic [9:0] lines;
    logic [5:0] vbp;
  } timing_t;

  // b[0] is the first parameter byte after the command.
  function automatic timing_t unpack_timing(input logic [7:0][7:0] b);
    timing_t t;
    t.disp_mode    = {b[0][5], b[0][1]};
    t.framing      = {b[0][3], b[0][0]};
    t.draw_retrace = b[0][4];
    t.refresh_en   = b[0][2];
    t.words        = {1'b0, b[1]} + 9'd2;
    t.hsync        = {1'b0, b[2][4:0]} + 6'd1;
    t.vsync        = {b[3][1:0], b[2][7:5]};
    t.hfp          = {1'b0, b[3][7:2]} + 7'd1;
    t.hbp          = {1'b0, b[4][5:0]} + 7'd1;
    t.vfp          = b[5][5:0];
    t.lines        = {b[7][1:0], b[6]};
    t.vbp          = b[7][7:2];
    return t;
  endfunction

endpackage

// File: rtl/gdc_cmd_fifo.sv
module gdc_cmd_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  input  logic         flush,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         overrun
);
  // DEPTH is expected to be a power of two so the pointers wrap naturally.
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovr_q, ovr_d;
  logic          accept, take;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign accept = push & ~full & ~flush;
  assign take   = pop & ~empty & ~flush;
  assign head   = mem[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    ovr_d  = ovr_q | (push & full & ~flush);
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (accept) wptr_d = wptr_q + AW'(1);
      if (take)   rptr_d = rptr_q + AW'(1);
      if (accept && !take)      cnt_d = cnt_q + CW'(1);
      else if (take && !accept) cnt_d = cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
      ovr_q  <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wptr_q] <= push_data;
  end

  assign overrun = ovr_q;

endmodule

// File: rtl/gdc_status.sv
module gdc_status (
  input  logic       empty,
  input  logic       full,
  input  logic       rd_ready,
  input  logic       hblank,
  input  logic       vblank,
  input  logic       vretrace,
  output logic [7:0] status
);
  always_comb begin
    status    = 8'h00;
    status[0] = rd_ready;
    status[1] = full;
    status[2] = empty;
    status[5] = vretrace;
    status[6] = hblank | vblank;
  end
endmodule

// File: rtl/gdc_cmd_decode.sv
module gdc_cmd_decode
  import gdc_cmd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pop,
  input  logic [ENTRY_W-1:0] entry,
  output logic               flush,
  output timing_t            timing,
  output logic               disp_en,
  output logic               idle,
  output logic               master_sync,
  output logic [8:0]         pitch,
  output logic [17:0]        cursor_addr,
  output logic               pram_we,
  output logic [PRAM_AW-1:0] pram_addr,
  output logic [7:0]         pram_wdata,
  output logic               rb_clr
);
  param_mode_e        mode_q, mode_d;
  logic [3:0]         step_q, step_d;
  logic [PRAM_AW-1:0] ptr_q, ptr_d;
  logic [6:0][7:0]    stage_q, stage_d;
  timing_t            tim_q, tim_d;
  logic               disp_q, disp_d, idle_q, idle_d, mst_q, mst_d;
  logic [8:0]         pitch_q, pitch_d;
  logic [17:0]        cur_q, cur_d;
  logic               pwe_q, pwe_d, rbc_q, rbc_d;
  logic [PRAM_AW-1:0] paddr_q, paddr_d;
  logic [7:0]         pdata_q, pdata_d;
  logic [7:0]         op;
  logic [7:0][7:0]    all_bytes;

  assign op        = entry[7:0];
  assign all_bytes = {op, stage_q};

  always_comb begin
    mode_d  = mode_q;   step_d  = step_q;  ptr_d  = ptr_q;
    stage_d = stage_q;  tim_d   = tim_q;   disp_d = disp_q;
    idle_d  = idle_q;   mst_d   = mst_q;   pitch_d = pitch_q;
    cur_d   = cur_q;    paddr_d = paddr_q; pdata_d = pdata_q;
    pwe_d   = 1'b0;     rbc_d   = 1'b0;    flush  = 1'b0;
    if (pop) begin
      if (entry[ENTRY_W-1]) begin
        step_d = '0;
        mode_d = PM_NONE;
        if (op == OP_RESET) begin
          disp_d = 1'b0;
          idle_d = 1'b1;
          mode_d = PM_TIMING;
          flush  = 1'b1;
          rbc_d  = 1'b1;
        end else if (op[7:1] == OP_BLANK[7:1]) begin
          disp_d = op[0];
        end else if (op[7:1] == OP_SYNC[7:1]) begin
          disp_d = op[0];
          mode_d = PM_TIMING;
        end else if (op == OP_PITCH) begin
          mode_d = PM_PITCH;
        end else if (op == OP_CURSOR) begin
          mode_d = PM_CURSOR;
        end else if (op == OP_START) begin
          disp_d = 1'b1;
          idle_d = 1'b0;
        end else if (op[7:1] == OP_VSMODE[7:1]) begin
          mst_d = op[0];
        end else if (op[7:4] == OP_PRAM[7:4]) begin
          ptr_d  = op[PRAM_AW-1:0];
          mode_d = PM_PRAM;
        end
      end else begin
        case (mode_q)
          PM_TIMING: begin
            if (step_q < 4'd8) begin
              step_d = step_q + 4'd1;
              if (step_q == 4'd7) tim_d = unpack_timing(all_bytes);
              else                stage_d[step_q[2:0]] = op;
            end
          end
          PM_PITCH: begin
            if (step_q == 4'd0) begin
              pitch_d = (op == 8'h00) ? 9'd256 : {1'b0, op};
              step_d  = 4'd1;
            end
          end
          PM_CURSOR: begin
            if (step_q < 4'd3) begin
              case (step_q[1:0])
                2'd0:    cur_d[7:0]   = op;
                2'd1:    cur_d[15:8]  = op;
                default: cur_d[17:16] = op[1:0];
              endcase
              step_d = step_q + 4'd1;
            end
          end
          PM_PRAM: begin
            pwe_d   = 1'b1;
            paddr_d = ptr_q;
            pdata_d = op;
            ptr_d   = ptr_q + PRAM_AW'(1);
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= PM_NONE;
      step_q  <= '0;
      ptr_q   <= '0;
      stage_q <= '0;
      tim_q   <= '0;
      disp_q  <= 1'b1;
      idle_q  <= 1'b0;
      mst_q   <= 1'b0;
      pitch_q <= 9'd256;
      cur_q   <= '0;
      pwe_q   <= 1'b0;
      paddr_q <= '0;
      pdata_q <= '0;
      rbc_q   <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      step_q  <= step_d;
      ptr_q   <= ptr_d;
      stage_q <= stage_d;
      tim_q   <= tim_d;
      disp_q  <= disp_d;
      idle_q  <= idle_d;
      mst_q   <= mst_d;
      pitch_q <= pitch_d;
      cur_q   <= cur_d;
      pwe_q   <= pwe_d;
      paddr_q <= paddr_d;
      pdata_q <= pdata_d;
      rbc_q   <= rbc_d;
    end
  end

  assign timing      = tim_q;
  assign disp_en     = disp_q;
  assign idle        = idle_q;
  assign master_sync = mst_q;
  assign pitch       = pitch_q;
  assign cursor_addr = cur_q;
  assign pram_we     = pwe_q;
  assign pram_addr   = paddr_q;
  assign pram_wdata  = pdata_q;
  assign rb_clr      = rbc_q;

endmodule

// File: rtl/gdc_cmd_front.sv
module gdc_cmd_front
  import gdc_cmd_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_cmd,
  input  logic        wr_param,
  input  logic [7:0]  wr_data,
  input  logic        step_en,
  input  logic        rd_ready,
  input  logic        hblank,
  input  logic        vblank,
  input  logic        vretrace,
  output logic [7:0]  status,
  output logic        overrun,
  output logic        disp_en,
  output logic        idle,
  output logic        master_sync,
  output logic [1:0]  disp_mode,
  output logic [1:0]  framing,
  output logic        draw_retrace,
  output logic        refresh_en,
  output logic [8:0]  words_per_line,
  output logic [5:0]  hsync_w,
  output logic [4:0]  vsync_w,
  output logic [6:0]  hfp_w,
  output logic [6:0]  hbp_w,
  output logic [5:0]  vfp_w,
  output logic [9:0]  active_lines,
  output logic [5:0]  vbp_w,
  output logic [8:0]  pitch,
  output logic [17:0] cursor_addr,
  output logic        pram_we,
  output logic [3:0]  pram_addr,
  output logic [7:0]  pram_wdata,
  output logic        rb_clr
);
  logic [1:0]         rst_sync_q;
  logic               rst_core_n;
  logic [ENTRY_W-1:0] head;
  logic               empty, full, pop, flush;
  timing_t            timing;

  // Reset asserts at once and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  assign pop = step_en & ~empty;

  gdc_cmd_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .push     (wr_cmd | wr_param),
    .push_data({wr_cmd, wr_data}),
    .pop      (pop),
    .flush    (flush),
    .head     (head),
    .empty    (empty),
    .full     (full),
    .overrun  (overrun)
  );

  gdc_cmd_decode u_dec (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .pop        (pop),
    .entry      (head),
    .flush      (flush),
    .timing     (timing),
    .disp_en    (disp_en),
    .idle       (idle),
    .master_sync(master_sync),
    .pitch      (pitch),
    .cursor_addr(cursor_addr),
    .pram_we    (pram_we),
    .pram_addr  (pram_addr),
    .pram_wdata (pram_wdata),
    .rb_clr     (rb_clr)
  );

  gdc_status u_stat (
    .empty   (empty),
    .full    (full),
    .rd_ready(rd_ready),
    .hblank  (hblank),
    .vblank  (vblank),
    .vretrace(vretrace),
    .status  (status)
  );

  assign disp_mode      = timing.disp_mode;
  assign framing        = timing.framing;
  assign draw_retrace   = timing.draw_retrace;
  assign refresh_en     = timing.refresh_en;
  assign words_per_line = timing.words;
  assign hsync_w        = timing.hsync;
  assign vsync_w        = timing.vsync;
  assign hfp_w          = timing.hfp;
  assign hbp_w          = timing.hbp;
  assign vfp_w          = timing.vfp;
  assign active_lines   = timing.lines;
  assign vbp_w          = timing.vbp;

endmodule

// File: rtl/gdc_cmd_front_chk.sv
module gdc_cmd_front_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       step_en,
  input logic       wr_cmd,
  input logic       wr_param,
  input logic [7:0] status,
  input logic       overrun,
  input logic       disp_en,
  input logic       idle,
  input logic       pram_we,
  input logic [3:0] pram_addr,
  input logic       rb_clr
);
  AST_NO_DECODE_WHEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> !pram_we && !rb_clr); // R1

  AST_EMPTY_FULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[2] && status[1])); // R2

  AST_UNUSED_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == 1'b0 && status[4:3] == 2'b00); // R2

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R3

  AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(status[1]) && $past(wr_cmd || wr_param)); // R3

  AST_RESET_CMD_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    rb_clr |-> status[2] && !disp_en && idle); // R4

  AST_PRAM_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pram_we) && pram_we |-> pram_addr == $past(pram_addr) + 4'd1); // R8
endmodule

bind gdc_cmd_front gdc_cmd_front_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step_en  (step_en),
  .wr_cmd   (wr_cmd),
  .wr_param (wr_param),
  .status   (status),
  .overrun  (overrun),
  .disp_en  (disp_en),
  .idle     (idle),
  .pram_we  (pram_we),
  .pram_addr(pram_addr),
  .rb_clr   (rb_clr)
);

// File: tb/gdc_cmd_front_tb.sv
module gdc_cmd_front_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_cmd = 1'b0, wr_param = 1'b0, step_en = 1'b1;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_ready = 1'b0, hblank = 1'b0, vblank = 1'b0, vretrace = 1'b0;
  logic [7:0]  status;
  logic        overrun, disp_en, idle, master_sync, draw_retrace, refresh_en;
  logic [1:0]  disp_mode, framing;
  logic [8:0]  words_per_line, pitch;
  logic [5:0]  hsync_w, vfp_w, vbp_w;
  logic [4:0]  vsync_w;
  logic [6:0]  hfp_w, hbp_w;
  logic [9:0]  active_lines;
  logic [17:0] cursor_addr;
  logic        pram_we, rb_clr;
  logic [3:0]  pram_addr;
  logic [7:0]  pram_wdata;

  int n_cmp = 0, n_bad = 0, n_rbclr = 0;
  bit done = 1'b0;
  logic [11:0] exp_q[$];

  always #10 clk = ~clk;

  gdc_cmd_front u_dut (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wr_param(wr_param),
    .wr_data(wr_data), .step_en(step_en), .rd_ready(rd_ready),
    .hblank(hblank), .vblank(vblank), .vretrace(vretrace),
    .status(status), .overrun(overrun), .disp_en(disp_en), .idle(idle),
    .master_sync(master_sync), .disp_mode(disp_mode), .framing(framing),
    .draw_retrace(draw_retrace), .refresh_en(refresh_en),
    .words_per_line(words_per_line), .hsync_w(hsync_w), .vsync_w(vsync_w),
    .hfp_w(hfp_w), .hbp_w(hbp_w), .vfp_w(vfp_w), .active_lines(active_lines),
    .vbp_w(vbp_w), .pitch(pitch), .cursor_addr(cursor_addr),
    .pram_we(pram_we), .pram_addr(pram_addr), .pram_wdata(pram_wdata),
    .rb_clr(rb_clr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic is_cmd, input logic [7:0] b);
    @(negedge clk);
    wr_cmd = is_cmd; wr_param = ~is_cmd; wr_data = b;
    @(negedge clk);
    wr_cmd = 1'b0; wr_param = 1'b0;
  endtask

  task automatic pram_expect(input logic [3:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // Scoreboard monitor: each RAM write pulse must match the next expected item.
  always @(negedge clk) begin
    if (rst_n && pram_we) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R8: unexpected write actual 0x%0h expected none", {pram_addr, pram_wdata});
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        if ({pram_addr, pram_wdata} !== e) begin
          n_bad++;
          $display("FAIL R8/R1: actual 0x%0h expected 0x%0h", {pram_addr, pram_wdata}, e);
        end
      end
    end
    if (rst_n && rb_clr) n_rbclr++;
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R12 reset state
    check("R12 disp_en", disp_en, 1);
    check("R12 idle", idle, 0);
    check("R12 master_sync", master_sync, 0);
    check("R12 pitch", pitch, 256);
    check("R12 cursor", cursor_addr, 0);
    check("R12 words", words_per_line, 0);
    check("R12 overrun", overrun, 0);
    check("R12 status", status, 8'h04);

    // R2 status composition
    rd_ready = 1; hblank = 1; vretrace = 1; #1;
    check("R2 status mix", status, 8'h65);
    rd_ready = 0; hblank = 0; vretrace = 0; vblank = 1; #1;
    check("R2 status vblank", status, 8'h44);
    vblank = 0;

    // R5 blank and start opcodes
    send(1, 8'h0C); settle(); check("R5 blank off", disp_en, 0);
    send(1, 8'h0D); settle(); check("R5 blank on", disp_en, 1);

    // R7 sync mode
    send(1, 8'h6F); settle(); check("R7 master set", master_sync, 1);
    send(1, 8'h6E); settle(); check("R7 master clr", master_sync, 0);

    // R9 cursor bytes, R11 extra byte ignored
    send(1, 8'h49); send(0, 8'h34); send(0, 8'h12); send(0, 8'hFE); settle();
    check("R9 cursor", cursor_addr, 18'h21234);
    send(0, 8'h55); settle();
    check("R11 cursor extra", cursor_addr, 18'h21234);

    // R10 pitch
    send(1, 8'h47); send(0, 8'h50); settle(); check("R10 pitch", pitch, 80);
    send(1, 8'h47); send(0, 8'h00); settle(); check("R10 pitch zero", pitch, 256);
    send(0, 8'h10); settle(); check("R11 pitch extra", pitch, 256);

    // R8 RAM load with wrap
    pram_expect(4'hE, 8'hA0); pram_expect(4'hF, 8'hA1); pram_expect(4'h0, 8'hA2);
    send(1, 8'h7E); send(0, 8'hA0); send(0, 8'hA1); send(0, 8'hA2); settle();
    check("R8 wrap drained", exp_q.size(), 0);

    // R6 timing pattern one via sync with display off
    send(1, 8'h0E);
    send(0, 8'h24); send(0, 8'd78); send(0, 8'hE7); send(0, 8'h25);
    send(0, 8'hC5); send(0, 8'h47); send(0, 8'h90); send(0, 8'h1D); settle();
    check("R5 sync disp", disp_en, 0);
    check("R6 mode", disp_mode, 2);
    check("R6 framing", framing, 0);
    check("R6 draw", draw_retrace, 0);
    check("R6 refresh", refresh_en, 1);
    check("R6 words", words_per_line, 80);
    check("R6 hsync", hsync_w, 8);
    check("R6 vsync", vsync_w, 15);
    check("R6 hfp", hfp_w, 10);
    check("R6 hbp", hbp_w, 6);
    check("R6 vfp", vfp_w, 7);
    check("R6 lines", active_lines, 400);
    check("R6 vbp", vbp_w, 7);
    send(0, 8'hFF); settle();
    check("R11 timing extra", words_per_line, 80);

    // R6 pattern two
    send(1, 8'h0F);
    send(0, 8'h19);
    for (int i = 0; i < 7; i++) send(0, 8'h00);
    settle();
    check("R5 sync disp on", disp_en, 1);
    check("R6 p2 mode", disp_mode, 0);
    check("R6 p2 framing", framing, 3);
    check("R6 p2 draw", draw_retrace, 1);
    check("R6 p2 words", words_per_line, 2);
    check("R6 p2 hsync", hsync_w, 1);
    check("R6 p2 lines", active_lines, 0);

    // R4 reset opcode flushes what follows it; R1 nothing decoded while held
    step_en = 0;
    send(1, 8'h00); send(1, 8'h70); send(0, 8'h55); settle();
    check("R1 held disp", disp_en, 1);
    check("R1 held status", status, 8'h00);
    step_en = 1; settle();
    check("R4 disp", disp_en, 0);
    check("R4 idle", idle, 1);
    check("R4 empty", status, 8'h04);
    check("R4 rb_clr", n_rbclr, 1);
    send(0, 8'h24); send(0, 8'd98); send(0, 8'hE7); send(0, 8'h25);
    send(0, 8'hC5); send(0, 8'h47); send(0, 8'h90); send(0, 8'h1D); settle();
    check("R4 timing", words_per_line, 100);
    send(1, 8'h6B); settle();
    check("R5 start disp", disp_en, 1);
    check("R5 start idle", idle, 0);

    // R11 parameter after no-parameter opcode
    send(1, 8'h0D); send(0, 8'h33); settle();
    check("R11 after blank", words_per_line, 100);
    check("R11 after blank pitch", pitch, 256);

    // R3 full queue drops the seventeenth entry
    step_en = 0;
    send(1, 8'h70);
    for (int i = 0; i < 16; i++) send(0, 8'(8'h10 + i));
    check("R3 full", status[1], 1);
    check("R3 overrun", overrun, 1);
    for (int i = 0; i < 15; i++) pram_expect(4'(i), 8'(8'h10 + i));
    step_en = 1;
    repeat (30) @(negedge clk);
    check("R3 drained", exp_q.size(), 0);
    check("R3 sticky", overrun, 1);
    check("R3 empty", status[2], 1);

    finish_run();
  end
endmodule